// File: doc/BRIEF.md
# Cluster Power-Mode Controller

This controller decides which parts of a split execution datapath receive an enable. The datapath has a floating-point cluster and an integer cluster, and the integer cluster is made of a lower and an upper half. The controller watches per-cycle activity over a window of cycles of fixed length. At the last cycle of each window it compares two totals against programmable thresholds. The first total is floating-point operations issued. The second is cycles in which the integer issue count was more than half the integer issue width. From that comparison it decides whether the floating-point cluster and the upper integer half stay powered for the next window.

The controller does not wait for the window to end when a floating-point instruction is fetched. The floating-point enable comes back on the next clock edge and is held until the end of the first complete window that follows. The lower integer half is never switched off, so integer work always has somewhere to run. An enable is only ever withdrawn in a cycle where the cluster reports that it has nothing in flight. The outputs are meant to drive clock-gating cells, which sit outside this block.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: During reset and right after it, `fp_en_o`, `upper_en_o` and `lower_en_o` are all 1, and the first window is 256 cycles long.
- R2: A window's floating-point count is the number of cycles in that window with `fp_issue_i` high. If this count is at least `fp_thresh_i` at the window's last cycle, `fp_en_o` is 1 during the next window. If it is below, `fp_en_o` becomes 0 (subject to R5 and R6). The new value appears at the clock edge of the first cycle of the next window.
- R3: A cycle counts as wide when `int_issue_num_i` is greater than ISSUE_W/2; with the default ISSUE_W=4 that means 3 or 4, and 2 is not wide. The wide count is compared against `wide_thresh_i` with the same rule and timing as R2, and the result drives `upper_en_o`.
- R4: `lower_en_o` is 1 in every cycle.
- R5: When `fp_fetch_i` is high in a cycle, `fp_en_o` is 1 after that cycle's clock edge. It then stays 1 through the end of the first complete window that begins after the fetch.
- R6: An enable output goes from 1 to 0 only at a clock edge where the matching busy input (`fp_busy_i` or `upper_busy_i`) is low. While the busy input stays high, the enable stays 1.
- R7: The window length is `win_len_i`, limited to the range 256 to 4096. The value is sampled at the last cycle of a window and applies from the next window on.
- R8: Both activity counts restart at zero at each window boundary, so each decision depends only on the events of its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len_i | input | 13 | Requested window length in cycles (limited to 256..4096) |
| fp_thresh_i | input | 13 | Minimum floating-point issue count that keeps the floating-point cluster on |
| wide_thresh_i | input | 13 | Minimum wide-issue cycle count that keeps the upper integer half on |
| int_issue_num_i | input | 3 | Integer operations issued this cycle (0..ISSUE_W) |
| fp_issue_i | input | 1 | A floating-point operation issued this cycle |
| fp_fetch_i | input | 1 | A floating-point instruction was fetched this cycle |
| fp_busy_i | input | 1 | The floating-point cluster has instructions in flight |
| upper_busy_i | input | 1 | The upper integer half has instructions in flight |
| fp_en_o | output | 1 | Registered enable for the floating-point cluster |
| upper_en_o | output | 1 | Registered enable for the upper integer half |
| lower_en_o | output | 1 | Registered enable for the lower integer half |

## Verification
The assertions assume the following about the inputs. `int_issue_num_i` never exceeds ISSUE_W. Each busy input eventually drops, so a pending withdrawal does complete. The fetch trigger is a level sampled on every edge, so a fetch held high is the same as a fetch repeated every cycle. The stimulus drives the issue count only with 2 or 3. It raises the busy input for a bounded number of cycles, pulses the fetch for a single cycle, and changes the window length in mid-window, which is the case where the sampling rule of R7 matters.

// File: rtl/cpc_pkg.sv
`timescale 1ns/1ps
package cpc_pkg;
  localparam int CPC_WIN_W   = 13;
  localparam int CPC_MIN_WIN = 256;
  localparam int CPC_MAX_WIN = 4096;
endpackage

// File: rtl/cpc_window_timer.sv
`timescale 1ns/1ps
// Counts the cycles of the current window. The requested length is
// sampled only in the window's last cycle.
module cpc_window_timer #(
  parameter int WIN_W   = 13,
  parameter int MIN_WIN = 256,
  parameter int MAX_WIN = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] len_i,
  output logic             win_end_o
);
  localparam logic [WIN_W-1:0] LO = WIN_W'(MIN_WIN);
  localparam logic [WIN_W-1:0] HI = WIN_W'(MAX_WIN);

  logic [WIN_W-1:0] cyc_q, len_q, len_clamped;

  always_comb begin
    if (len_i < LO)      len_clamped = LO;
    else if (len_i > HI) len_clamped = HI;
    else                 len_clamped = len_i;
  end

  assign win_end_o = (cyc_q == len_q - WIN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      len_q <= LO;
    end else if (win_end_o) begin
      cyc_q <= '0;
      len_q <= len_clamped;
    end else begin
      cyc_q <= cyc_q + WIN_W'(1);
    end
  end
endmodule

// File: rtl/cpc_event_monitor.sv
`timescale 1ns/1ps
// One activity counter with its threshold comparator. The decision is
// taken in the window's last cycle and includes that cycle's event.
module cpc_event_monitor #(
  parameter int WIN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             win_end_i,
  input  logic [WIN_W-1:0] thresh_i,
  output logic             want_o
);
  logic [WIN_W-1:0] cnt_q, total;

  assign total = cnt_q + WIN_W'(ev_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      want_o <= 1'b1;
    end else if (win_end_i) begin
      cnt_q  <= '0;
      want_o <= (total >= thresh_i);
    end else begin
      cnt_q  <= total;
    end
  end
endmodule

// File: rtl/cpc_enable_gate.sv
`timescale 1ns/1ps
// Registered enable. It turns on at once and turns off only when the
// cluster has nothing in flight.
module cpc_enable_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       en_o <= 1'b1;
    else if (req_i)   en_o <= 1'b1;
    else if (!busy_i) en_o <= 1'b0;
  end
endmodule

// File: rtl/cluster_pwr_ctrl.sv
`timescale 1ns/1ps
module cluster_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int  ISSUE_W  = 4,
  parameter int  WIN_W    = CPC_WIN_W,
  parameter int  MIN_WIN  = CPC_MIN_WIN,
  parameter int  MAX_WIN  = CPC_MAX_WIN,
  localparam int ISSUE_CW = $clog2(ISSUE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIN_W-1:0]    win_len_i,
  input  logic [WIN_W-1:0]    fp_thresh_i,
  input  logic [WIN_W-1:0]    wide_thresh_i,
  input  logic [ISSUE_CW-1:0] int_issue_num_i,
  input  logic                fp_issue_i,
  input  logic                fp_fetch_i,
  input  logic                fp_busy_i,
  input  logic                upper_busy_i,
  output logic                fp_en_o,
  output logic                upper_en_o,
  output logic                lower_en_o
);
  localparam int NMON = 2;  // monitor 0: floating point, 1: wide integer issue

  logic            win_end;
  logic [NMON-1:0] mon_ev, mon_want;
  logic [WIN_W-1:0] mon_thr [NMON];
  logic            fp_want, up_want;
  logic [1:0]      hold_q;  // window boundaries left before the trigger expires

  cpc_window_timer #(.WIN_W(WIN_W), .MIN_WIN(MIN_WIN), .MAX_WIN(MAX_WIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .len_i(win_len_i), .win_end_o(win_end)
  );

  assign mon_ev[0]  = fp_issue_i;
  assign mon_ev[1]  = (int_issue_num_i > ISSUE_CW'(ISSUE_W / 2));
  assign mon_thr[0] = fp_thresh_i;
  assign mon_thr[1] = wide_thresh_i;

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    cpc_event_monitor #(.WIN_W(WIN_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .ev_i(mon_ev[g]), .win_end_i(win_end),
      .thresh_i(mon_thr[g]), .want_o(mon_want[g])
    );
  end

  assign fp_want = mon_want[0];
  assign up_want = mon_want[1];

  // A fetch inside a window must outlive the partial window and one full
  // window. A fetch in a boundary cycle only needs the full window.
  always_ff @(posedge clk) begin
    if (!rst_n)                         hold_q <= 2'd0;
    else if (fp_fetch_i)                hold_q <= win_end ? 2'd1 : 2'd2;
    else if (win_end && hold_q != 2'd0) hold_q <= hold_q - 2'd1;
  end

  cpc_enable_gate u_fp_gate (
    .clk(clk), .rst_n(rst_n),
    .req_i(fp_fetch_i || hold_q != 2'd0 || fp_want),
    .busy_i(fp_busy_i), .en_o(fp_en_o)
  );

  cpc_enable_gate u_up_gate (
    .clk(clk), .rst_n(rst_n), .req_i(up_want),
    .busy_i(upper_busy_i), .en_o(upper_en_o)
  );

  always_ff @(posedge clk) begin
    lower_en_o <= 1'b1;
  end
endmodule

// File: rtl/cpc_checker.sv
`timescale 1ns/1ps
module cpc_checker (
  input logic clk,
  input logic rst_n,
  input logic fp_fetch_i,
  input logic fp_busy_i,
  input logic upper_busy_i,
  input logic fp_en_o,
  input logic upper_en_o,
  input logic lower_en_o,
  input logic win_end,
  input logic fp_want,
  input logic up_want
);
  assert_lower_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lower_en_o);

  assert_fetch_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fp_fetch_i |=> fp_en_o);

  assert_fp_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fp_en_o) |-> !$past(fp_busy_i));

  assert_up_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upper_en_o) |-> !$past(upper_busy_i));

  assert_fp_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(fp_want));

  assert_up_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(up_want));
endmodule

bind cluster_pwr_ctrl cpc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fp_fetch_i(fp_fetch_i), .fp_busy_i(fp_busy_i),
  .upper_busy_i(upper_busy_i), .fp_en_o(fp_en_o), .upper_en_o(upper_en_o),
  .lower_en_o(lower_en_o), .win_end(win_end), .fp_want(fp_want), .up_want(up_want)
);

// File: tb/tb_cluster_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_cluster_pwr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] win_len_i = 13'd256, fp_thresh_i = 13'd10, wide_thresh_i = 13'd20;
  logic [2:0]  int_issue_num_i = 3'd0;
  logic        fp_issue_i = 1'b0, fp_fetch_i = 1'b0, fp_busy_i = 1'b0, upper_busy_i = 1'b0;
  logic        fp_en_o, upper_en_o, lower_en_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Expected results of the previous window, checked in cycle 1 of the next.
  bit pend_valid = 1'b0;
  logic pend_fp, pend_up;
  string pend_tag;
  int fetch_at = -1, busy_until = 0, xchk_at = -1, xchk_sel = 0;
  logic xchk_exp;
  string xchk_tag;

  always #4 clk = ~clk;

  cluster_pwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .win_len_i(win_len_i), .fp_thresh_i(fp_thresh_i),
    .wide_thresh_i(wide_thresh_i), .int_issue_num_i(int_issue_num_i),
    .fp_issue_i(fp_issue_i), .fp_fetch_i(fp_fetch_i), .fp_busy_i(fp_busy_i),
    .upper_busy_i(upper_busy_i), .fp_en_o(fp_en_o), .upper_en_o(upper_en_o),
    .lower_en_o(lower_en_o)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // Entered at a falling edge, just before the edge of window cycle 0.
  task automatic run_win(input int len, input int fp_first, input int fp_cnt,
                         input int wide_cnt, input int nxt_len,
                         input logic exp_fp, input logic exp_up, input string tag);
    for (int i = 0; i < len; i++) begin
      if (i == 1 && pend_valid) begin
        chk(fp_en_o, pend_fp, {pend_tag, " fp_en"});
        chk(upper_en_o, pend_up, {pend_tag, " upper_en"});
        chk(lower_en_o, 1'b1, "R4 lower_en");
      end
      if (i == xchk_at)
        chk(xchk_sel == 0 ? fp_en_o : upper_en_o, xchk_exp, xchk_tag);
      fp_issue_i      = (i >= fp_first) && (i < fp_first + fp_cnt);
      int_issue_num_i = (i < wide_cnt) ? 3'd3 : 3'd2;
      fp_fetch_i      = (i == fetch_at);
      upper_busy_i    = (i < busy_until);
      if (i == 5) win_len_i = 13'(nxt_len);
      @(negedge clk);
    end
    pend_valid = 1'b1;
    pend_fp = exp_fp;
    pend_up = exp_up;
    pend_tag = tag;
  endtask

  // fp count, wide count, expected fp_en, expected upper_en (thresholds 10 / 20)
  localparam int NVEC = 7;
  localparam int VEC [NVEC][4] = '{
    '{0,   0,   0, 0},
    '{10,  20,  1, 1},
    '{9,   20,  0, 1},
    '{10,  19,  1, 0},
    '{40,  100, 1, 1},
    '{0,   255, 0, 1},
    '{256, 0,   1, 0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(fp_en_o, 1'b1, "R1 reset fp_en");
    chk(upper_en_o, 1'b1, "R1 reset upper_en");
    chk(lower_en_o, 1'b1, "R1 reset lower_en");
    rst_n = 1'b1;

    // Table walk: thresholds and equality edges (R2, R3, R8); the first
    // window also confirms the 256-cycle reset length (R1).
    for (int v = 0; v < NVEC; v++)
      run_win(256, 0, VEC[v][0], VEC[v][1], 256, 1'(VEC[v][2]), 1'(VEC[v][3]),
              "R2/R3/R8 table");

    // R5: fetch in mid-window, held through the following full window.
    run_win(256, 0, 0, 0, 256, 1'b0, 1'b0, "R2 idle");
    fetch_at = 100; xchk_at = 101; xchk_sel = 0; xchk_exp = 1'b1; xchk_tag = "R5 fetch next edge";
    run_win(256, 0, 0, 0, 256, 1'b1, 1'b0, "R5 hold after partial window");
    fetch_at = -1; xchk_at = 255; xchk_tag = "R5 hold late in full window";
    run_win(256, 0, 0, 0, 256, 1'b0, 1'b0, "R5 hold expired");
    xchk_at = -1;

    // R6: upper half stays on while busy, drops once idle.
    run_win(256, 0, 0, 30, 256, 1'b0, 1'b1, "R3 upper back on");
    busy_until = 100000;
    run_win(256, 0, 0, 0, 256, 1'b0, 1'b1, "R6 held while busy");
    busy_until = 10; xchk_at = 11; xchk_sel = 1; xchk_exp = 1'b0; xchk_tag = "R6 drop when idle";
    run_win(256, 0, 0, 0, 256, 1'b0, 1'b0, "R6 idle window");
    busy_until = 0; xchk_at = -1;

    // R7: length taken only at the window end, and limited to 256.
    run_win(256, 0, 10, 0, 300, 1'b1, 1'b0, "R7 before change");
    run_win(300, 260, 10, 0, 10, 1'b1, 1'b0, "R7 300-cycle window");
    run_win(256, 200, 9, 0, 256, 1'b0, 1'b0, "R7 clamped to 256");
    run_win(2, 0, 0, 0, 256, 1'b0, 1'b0, "flush");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule